// File: doc/BRIEF.md
# Guarded Control Register Write Sequencer

This block holds one 8-bit control register. The register has two volatile enable latches and a set of persistent configuration fields: a 2-bit watchdog interval select, a 2-bit power-up delay select and a block-protect bit. A three-step unlock protocol guards the persistent fields. First a byte arms the write-enable latch. A second byte arms the register-write-enable latch. Only a third byte, with the escape bit clear, loads the persistent fields. Each accepted action takes effect on the stop that closes its transaction. A commit then holds a busy flag for a parameterised number of clock cycles, which stands in for a nonvolatile write time.

The block sits behind a serial slave that has already decoded the bus. That slave passes in start and stop events, one pulse per received data byte together with an address-match flag, and read requests. For every matched byte the block answers with a one-cycle acknowledge or negative-acknowledge pulse. It presents the current register on a read port and drives the persistent fields out to the watchdog and reset logic.

Top module: `ctrl_guard_seq`

## Requirements
- R1: After reset, WEL and RWEL are 0, the watchdog select is 11, the power-up select is 01, block-protect is 0, busy is low, and the register reads 61h.
- R2: While WEL is 0, only data byte 02h is acknowledged. Any other byte is negative-acknowledged and changes no state.
- R3: With RWEL clear, byte 02h sets WEL and byte 00h clears WEL. Neither raises busy.
- R4: With WEL set and RWEL clear, byte 06h sets RWEL and keeps WEL. Any byte other than 00h, 02h or 06h is negative-acknowledged and ignored. RWEL is never 1 while WEL is 0.
- R5: With RWEL set, any byte with bit 2 clear is acknowledged. At the stop it loads bits 7, 6, 5, 4 and 0 into PUP1, WD1, WD0, BP and PUP0. It also clears RWEL, keeps WEL, and raises busy for exactly COMMIT_CYCLES cycles.
- R6: With RWEL set, a byte with bit 2 set is acknowledged. It keeps RWEL set, leaves the persistent fields unchanged and raises no busy.
- R7: A second matched data byte in one transaction is negative-acknowledged. It also discards the action of the first byte.
- R8: An accepted action takes effect only at the stop that ends its transaction. A new start before that stop discards it. Reads at any point leave the state unchanged.
- R9: While busy is high, every matched byte is negative-acknowledged and ignored.
- R10: One cycle after a read request, the read port holds {PUP1, WD1, WD0, BP, 0, RWEL, WEL, PUP0} from bit 7 down to bit 0, with bit 3 always 0.
- R11: The response to a matched byte is a single pulse on either acknowledge or negative-acknowledge, one cycle after the byte. A byte with the match flag low gets no response. A byte outside an open transaction is negative-acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| txn_start_i | input | 1 | Start or repeated start seen on the bus (pulse) |
| txn_stop_i | input | 1 | Stop seen on the bus (pulse) |
| byte_valid_i | input | 1 | A data byte has been received (pulse) |
| byte_sel_i | input | 1 | The byte is addressed to this register |
| byte_data_i | input | 8 | Received data byte |
| rd_req_i | input | 1 | Read request for the register |
| ack_o | output | 1 | Byte accepted (pulse) |
| nack_o | output | 1 | Byte refused (pulse) |
| busy_o | output | 1 | Persistent commit in progress |
| rd_data_o | output | 8 | Register value captured at the last read request |
| wd_sel_o | output | 2 | Watchdog interval select |
| pup_sel_o | output | 2 | Power-up delay select |
| bp_o | output | 1 | Block-protect bit |

## Verification
The unlock path is driven in directed order: refused bytes while locked, 02h, 06h, an escape byte, a commit value, then 00h. These steps show that each latch level admits exactly its own codes and that the escape and commit forms of a third byte stay distinct. Two-byte transactions, repeated starts without a stop and reads placed mid-sequence separate "accepted at the byte" from "applied at the stop". Writes sent during the busy window show that its length is exact and that refusal comes from the timer rather than the latch state. Random transactions then mix the three codes, escape bytes, arbitrary values, reads and variable idle gaps. Each one is checked against a bench model of the latch states.

// File: rtl/cguard_pkg.sv
// Package: shared types and field positions for the guarded control register.
// Assumes an 8-bit register whose bit positions are fixed by the software view.
package cguard_pkg;

    // Action recorded from an accepted byte, applied at the following stop.
    typedef enum logic [2:0] {
        ACT_NONE      = 3'd0,
        ACT_SET_WEL   = 3'd1,
        ACT_CLR_WEL   = 3'd2,
        ACT_ARM_RWEL  = 3'd3,
        ACT_HOLD_RWEL = 3'd4,
        ACT_COMMIT    = 3'd5
    } act_e;

    // Persistent configuration fields.
    typedef struct packed {
        logic [1:0] pup;
        logic [1:0] wd;
        logic       bp;
    } persist_t;

    localparam int unsigned REG_W    = 8;
    localparam int unsigned B_PUP1   = 7;
    localparam int unsigned B_WD1    = 6;
    localparam int unsigned B_WD0    = 5;
    localparam int unsigned B_BP     = 4;
    localparam int unsigned B_ESC    = 2;
    localparam int unsigned B_PUP0   = 0;

    localparam logic [REG_W-1:0] CODE_WEL_OFF = 8'h00;
    localparam logic [REG_W-1:0] CODE_WEL_ON  = 8'h02;
    localparam logic [REG_W-1:0] CODE_ARM     = 8'h06;

    // Assemble the software-visible register image.
    function automatic logic [REG_W-1:0] pack_reg(input persist_t p, input logic rwel,
                                                  input logic wel);
        return {p.pup[1], p.wd[1], p.wd[0], p.bp, 1'b0, rwel, wel, p.pup[0]};
    endfunction

    // Extract the persistent fields from a commit byte.
    function automatic persist_t unpack_persist(input logic [REG_W-1:0] d);
        persist_t p;
        p.pup = {d[B_PUP1], d[B_PUP0]};
        p.wd  = {d[B_WD1], d[B_WD0]};
        p.bp  = d[B_BP];
        return p;
    endfunction

endpackage

// File: rtl/cguard_decode.sv
// Module: classifies a received byte against the current latch state.
// Assumes latch state only changes at stops, so the inputs are stable for the byte.
module cguard_decode
    import cguard_pkg::*;
(
    input  logic [REG_W-1:0] data_i,
    input  logic             wel_i,
    input  logic             rwel_i,
    input  logic             busy_i,
    output act_e             act_o,
    output logic             accept_o
);

    // Priority: busy refuses everything, then RWEL level, then WEL level, then locked.
    always_comb begin
        act_o    = ACT_NONE;
        accept_o = 1'b0;
        if (busy_i) begin
            act_o    = ACT_NONE;
        end else if (rwel_i) begin
            accept_o = 1'b1;
            act_o    = data_i[B_ESC] ? ACT_HOLD_RWEL : ACT_COMMIT;
        end else if (wel_i) begin
            if (data_i == CODE_WEL_OFF) begin
                accept_o = 1'b1;
                act_o    = ACT_CLR_WEL;
            end else if (data_i == CODE_WEL_ON) begin
                accept_o = 1'b1;
                act_o    = ACT_SET_WEL;
            end else if (data_i == CODE_ARM) begin
                accept_o = 1'b1;
                act_o    = ACT_ARM_RWEL;
            end
        end else if (data_i == CODE_WEL_ON) begin
            accept_o = 1'b1;
            act_o    = ACT_SET_WEL;
        end
    end

endmodule

// File: rtl/cguard_timer.sv
// Module: emulated nonvolatile commit timer; busy for COMMIT_CYCLES cycles after a load.
// Assumes load_i is never raised while busy (the caller refuses writes then).
module cguard_timer #(
    parameter int unsigned COMMIT_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic busy_o
);

    localparam int unsigned CNT_W = $clog2(COMMIT_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(COMMIT_CYCLES);

    logic [CNT_W-1:0] cnt_q;

    // Load the window on a commit, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= CNT_LOAD;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy_o = (cnt_q != '0);

    assert_load_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> busy_o);
    assert_idle_stays_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !load_i) |=> !busy_o);

endmodule

// File: rtl/ctrl_guard_seq.sv
// Module: guarded control register with a three-step unlock before persistent writes.
// Assumes decoded bus events: start and stop never share a cycle with each other
// or with a byte pulse; a byte pulse carries its address-match flag and data.
module ctrl_guard_seq
    import cguard_pkg::*;
#(
    parameter int unsigned COMMIT_CYCLES = 1000,
    parameter logic [1:0]  RST_WD        = 2'b11,
    parameter logic [1:0]  RST_PUP       = 2'b01,
    parameter logic        RST_BP        = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             txn_start_i,
    input  logic             txn_stop_i,
    input  logic             byte_valid_i,
    input  logic             byte_sel_i,
    input  logic [REG_W-1:0] byte_data_i,
    input  logic             rd_req_i,
    output logic             ack_o,
    output logic             nack_o,
    output logic             busy_o,
    output logic [REG_W-1:0] rd_data_o,
    output logic [1:0]       wd_sel_o,
    output logic [1:0]       pup_sel_o,
    output logic             bp_o
);

    localparam persist_t PERSIST_RST = '{pup: RST_PUP, wd: RST_WD, bp: RST_BP};

    logic             wel_q, rwel_q;
    persist_t         persist_q;
    logic             in_txn_q, seen_q;
    act_e             pend_q;
    logic [REG_W-1:0] pend_data_q;
    logic             ack_q, nack_q;
    logic [REG_W-1:0] rd_q;

    act_e             dec_act;
    logic             dec_accept;
    logic             byte_hit, byte_ok, commit_go;

    cguard_decode u_decode (
        .data_i   (byte_data_i),
        .wel_i    (wel_q),
        .rwel_i   (rwel_q),
        .busy_i   (busy_o),
        .act_o    (dec_act),
        .accept_o (dec_accept)
    );

    assign byte_hit  = byte_valid_i && byte_sel_i;
    assign byte_ok   = dec_accept && in_txn_q && !seen_q;
    assign commit_go = txn_stop_i && !txn_start_i && in_txn_q && (pend_q == ACT_COMMIT);

    cguard_timer #(.COMMIT_CYCLES(COMMIT_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (commit_go),
        .busy_o (busy_o)
    );

    // One response pulse per matched byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q  <= 1'b0;
            nack_q <= 1'b0;
        end else begin
            ack_q  <= byte_hit && byte_ok;
            nack_q <= byte_hit && !byte_ok;
        end
    end

    // Transaction tracking: open on start, close on stop, remember one pending action.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_txn_q    <= 1'b0;
            seen_q      <= 1'b0;
            pend_q      <= ACT_NONE;
            pend_data_q <= '0;
        end else if (txn_start_i) begin
            in_txn_q <= 1'b1;
            seen_q   <= 1'b0;
            pend_q   <= ACT_NONE;
        end else if (txn_stop_i) begin
            in_txn_q <= 1'b0;
            seen_q   <= 1'b0;
            pend_q   <= ACT_NONE;
        end else if (byte_hit) begin
            seen_q <= 1'b1;
            if (byte_ok) begin
                pend_q      <= dec_act;
                pend_data_q <= byte_data_i;
            end else begin
                pend_q <= ACT_NONE;
            end
        end
    end

    // Apply the pending action to the latches and persistent fields at the stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel_q     <= 1'b0;
            rwel_q    <= 1'b0;
            persist_q <= PERSIST_RST;
        end else if (txn_stop_i && !txn_start_i && in_txn_q) begin
            case (pend_q)
                ACT_SET_WEL:  wel_q <= 1'b1;
                ACT_CLR_WEL:  wel_q <= 1'b0;
                ACT_ARM_RWEL: begin
                    wel_q  <= 1'b1;
                    rwel_q <= 1'b1;
                end
                ACT_COMMIT: begin
                    persist_q <= unpack_persist(pend_data_q);
                    rwel_q    <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    // Capture the register image on a read request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (rd_req_i) begin
            rd_q <= pack_reg(persist_q, rwel_q, wel_q);
        end
    end

    assign ack_o     = ack_q;
    assign nack_o    = nack_q;
    assign rd_data_o = rd_q;
    assign wd_sel_o  = persist_q.wd;
    assign pup_sel_o = persist_q.pup;
    assign bp_o      = persist_q.bp;

    assert_locked_nack_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_hit && !wel_q && byte_data_i != CODE_WEL_ON) |=> (nack_o && !ack_o));
    assert_rwel_needs_wel_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rwel_q |-> wel_q);
    assert_second_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_hit && seen_q && !txn_start_i) |=> nack_o);
    assert_persist_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_go |=> $stable(persist_q));
    assert_busy_nack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_hit && busy_o) |=> nack_o);
    assert_one_resp_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack_o && nack_o));
    assert_unsel_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(byte_valid_i && byte_sel_i) |=> !(ack_o || nack_o));

endmodule

// File: tb/tb_ctrl_guard_seq.sv
module tb_ctrl_guard_seq;

    localparam int C = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       txn_start = 1'b0, txn_stop = 1'b0, byte_valid = 1'b0, byte_sel = 1'b0;
    logic [7:0] byte_data = 8'h00;
    logic       rd_req = 1'b0;
    logic       ack, nack, busy, bp;
    logic [7:0] rd_data;
    logic [1:0] wd_sel, pup_sel;

    always #5 clk = ~clk;

    ctrl_guard_seq #(.COMMIT_CYCLES(C)) dut (
        .clk(clk), .rst_n(rst_n), .txn_start_i(txn_start), .txn_stop_i(txn_stop),
        .byte_valid_i(byte_valid), .byte_sel_i(byte_sel), .byte_data_i(byte_data),
        .rd_req_i(rd_req), .ack_o(ack), .nack_o(nack), .busy_o(busy),
        .rd_data_o(rd_data), .wd_sel_o(wd_sel), .pup_sel_o(pup_sel), .bp_o(bp)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // Bench model of the register state.
    bit         m_wel, m_rwel, m_bp, m_in_txn, m_seen;
    logic [1:0] m_wd, m_pup;
    int         m_busy_end, m_pend;
    logic [7:0] m_pdata;
    int         n_chk = 0, n_bad = 0;
    bit         done = 1'b0;

    function automatic logic [7:0] exp_reg();
        return {m_pup[1], m_wd, m_bp, 1'b0, m_rwel, m_wel, m_pup[0]};
    endfunction

    // 0 refuse, 1 set WEL, 2 clear WEL, 3 arm RWEL, 4 hold RWEL, 5 commit
    function automatic int exp_act(logic [7:0] d, bit bsy);
        if (bsy) return 0;
        if (m_rwel) return d[2] ? 4 : 5;
        if (m_wel) begin
            if (d == 8'h00) return 2;
            if (d == 8'h02) return 1;
            if (d == 8'h06) return 3;
            return 0;
        end
        return (d == 8'h02) ? 1 : 0;
    endfunction

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic t_start();
        @(negedge clk) txn_start = 1'b1;
        @(negedge clk) txn_start = 1'b0;
        m_in_txn = 1'b1; m_seen = 1'b0; m_pend = 0;
    endtask

    task automatic t_byte(logic [7:0] d, bit sel);
        bit    bsy;
        int    a;
        bit    ok;
        string tag;
        @(negedge clk);
        bsy = (cyc < m_busy_end);
        byte_valid = 1'b1; byte_sel = sel; byte_data = d;
        @(negedge clk);
        byte_valid = 1'b0; byte_sel = 1'b0;
        if (!sel) begin
            chk(!ack && !nack, "R11 unselected byte silent", {ack, nack}, 0);
            return;
        end
        a  = exp_act(d, bsy);
        ok = (a != 0) && m_in_txn && !m_seen;
        if (bsy) tag = "R9 busy refuse";
        else if (!m_in_txn) tag = "R11 outside txn";
        else if (m_seen) tag = "R7 second byte";
        else if (!m_wel) tag = "R2 locked";
        else if (m_rwel) tag = "R5/R6 third byte";
        else tag = "R4 wel level";
        chk({ack, nack} == {ok, !ok}, tag, {ack, nack}, {ok, !ok});
        if (m_in_txn) begin
            m_seen = 1'b1;
            m_pend = ok ? a : 0;
            m_pdata = d;
        end
    endtask

    task automatic t_stop();
        bit was;
        @(negedge clk) txn_stop = 1'b1;
        @(negedge clk) txn_stop = 1'b0;
        if (m_in_txn) begin
            case (m_pend)
                1: m_wel = 1'b1;
                2: m_wel = 1'b0;
                3: begin m_wel = 1'b1; m_rwel = 1'b1; end
                5: begin
                    m_pup = {m_pdata[7], m_pdata[0]}; m_wd = m_pdata[6:5];
                    m_bp = m_pdata[4]; m_rwel = 1'b0; m_busy_end = cyc + C;
                end
                default: ;
            endcase
        end
        was = (m_pend == 5) && m_in_txn;
        m_in_txn = 1'b0; m_seen = 1'b0; m_pend = 0;
        chk(busy == (cyc < m_busy_end), was ? "R5 busy on commit" : "R3 no busy",
            busy, (cyc < m_busy_end));
    endtask

    task automatic t_read(string tag);
        @(negedge clk) rd_req = 1'b1;
        @(negedge clk) rd_req = 1'b0;
        chk(rd_data == exp_reg(), tag, rd_data, exp_reg());
        chk({pup_sel, wd_sel, bp} == {m_pup, m_wd, m_bp}, "R5 field outputs",
            {pup_sel, wd_sel, bp}, {m_pup, m_wd, m_bp});
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=0", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int r;
        logic [7:0] d;
        m_wel = 0; m_rwel = 0; m_wd = 2'b11; m_pup = 2'b01; m_bp = 0;
        m_busy_end = 0; m_in_txn = 0; m_seen = 0; m_pend = 0; m_pdata = 0;
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk(busy == 1'b0, "R1 busy at reset", busy, 0);
        t_read("R1 reset image 61h");
        chk(rd_data == 8'h61, "R1 literal 61h", rd_data, 8'h61);
        // R2 locked: 06h and A5h refused
        t_start(); t_byte(8'h06, 1); t_stop();
        t_start(); t_byte(8'hA5, 1); t_stop();
        t_read("R2 state unchanged");
        // R3 set WEL
        t_start(); t_byte(8'h02, 1); t_stop();
        t_read("R3 WEL set 63h");
        // R8 repeated start discards pending clear
        t_start(); t_byte(8'h00, 1); t_start(); t_stop();
        t_read("R8 discarded by restart");
        // R4 arm RWEL, with a read between start and stop
        t_start(); t_byte(8'h06, 1); t_read("R8 read mid txn"); t_stop();
        t_read("R4 RWEL set 67h");
        // R6 escape keeps RWEL
        t_start(); t_byte(8'hF6, 1); t_stop();
        t_read("R6 escape keeps 67h");
        // R7 second byte aborts
        t_start(); t_byte(8'h90, 1); t_byte(8'h02, 1); t_stop();
        t_read("R7 abort keeps 67h");
        // R5 commit B1h -> image B3h, exact busy window
        t_start(); t_byte(8'hB1, 1); t_stop();
        t_read("R10 image after commit B3h");
        chk(rd_data == 8'hB3, "R10 literal B3h", rd_data, 8'hB3);
        t_start(); t_byte(8'h02, 1); t_stop();   // R9 refused while busy
        while (cyc < m_busy_end - 1) @(negedge clk);
        chk(busy == 1'b1, "R5 busy last cycle", busy, 1);
        @(negedge clk);
        chk(busy == 1'b0, "R5 busy ends", busy, 0);
        // R3 clear WEL
        t_start(); t_byte(8'h00, 1); t_stop();
        t_read("R3 WEL cleared B1h");
        // R11 unselected byte and byte outside a transaction
        t_start(); t_byte(8'h02, 0); t_stop();
        t_byte(8'h02, 1);
        t_read("R11 no state change");
        // Random mix
        for (int i = 0; i < 600; i++) begin
            r = $urandom % 100;
            t_start();
            for (int b = 0; b < ((r < 12) ? 2 : 1); b++) begin
                case ($urandom % 6)
                    0: d = 8'h00;
                    1: d = 8'h02;
                    2, 3: d = 8'h06;
                    4: d = 8'($urandom) | 8'h04;
                    default: d = 8'($urandom);
                endcase
                t_byte(d, ($urandom % 10) != 0);
                if (($urandom % 5) == 0) t_read("R8 random mid read");
            end
            if (r < 92) t_stop();
            if (($urandom % 4) == 0) idle($urandom % 25);
            if (($urandom % 3) == 0) t_read("R10 random read");
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule